// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block is one DMA channel. It moves a programmed number of transfer cycles from a source address to a destination address over a simple memory-master port. Software sets it up through four 32-bit registers on a register-bus slave port, then starts it by setting the enable bit. Each unit is read from the source and then written to the destination. Both addresses step on their own after every unit, and each can count up, count down or stay fixed. In burst mode one cycle moves four units. Otherwise one cycle moves a single unit.

A cycle can be made to wait on a peripheral request line, chosen separately for the source side and the destination side. When the last unit of the cycle has been written, the channel answers with a one-clock grant on each selected line. At the end of the transfer, or on a bus error, a status bit is set and the enable bit drops. A level interrupt follows the status bits through their own enable bits. Reading the cycle counter during a transfer returns the number of cycles still to do.

Top module: `dma_chan`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, `mem_req` is 0 and `dgrant` is all zeros.
- R2: The register index selects the register: 0 is the source address, 1 the destination address, 2 the cycle count and 3 the control word. The cycle count keeps 24 bits and reads back with the upper bits zero. The control word keeps only its defined bits. These are bit 0 enable, 1 finish status, 2 finish interrupt enable, 3 burst, 4 error status, 5 error interrupt enable, 6 source bus select and 7 destination bus select. Bits 10:8 hold the source step code, 14:12 the destination step code, 19:16 the destination request line, 21:20 the width and 27:24 the source request line. All other bits read as 0.
- R3: After each unit the address moves by its step code. Code 001 adds 1, 010 adds 2 and 011 adds 4. Code 101 subtracts 1, 110 subtracts 2 and 111 subtracts 4. Code 000 (and 100) leaves the address unchanged. Because of this, a burst cycle moves an address by four times the step.
- R4: Each unit is a read at the source address followed by a write to the destination address that carries the data just read. `mem_size` equals control bits 21:20 (00 word, 01 half, 10 byte). `mem_sysbus` equals bit 6 during reads and bit 7 during writes.
- R5: With burst set, each cycle performs four units, so a count of N gives 4N read/write pairs.
- R6: When the last cycle finishes, the finish status bit is set, enable reads 0 and `mem_req` falls. `irq` equals (finish status AND bit 2) OR (error status AND bit 5).
- R7: With a nonzero request line field, a cycle does not start until `dreq` of that line is high. No memory request is issued while it is low. After the last write of each cycle, `dgrant` of each selected line pulses for exactly one clock.
- R8: The cycle count register drops by one as each cycle completes, so a read during a transfer returns the cycles not yet done.
- R9: A `mem_err` returned with `mem_ready` sets the error status bit, clears enable and stops the transfer. The cycle in progress is not counted.
- R10: Writing a status bit as 0 in the control word clears it. Writing it as 1 leaves it unchanged.
- R11: Setting enable while the count is 0 sets finish status at once, issues no memory request and leaves enable at 0.
- R12: Writes to the source, destination and count registers are ignored while a transfer is running.
- R13: Writing the control word with enable 0 during a transfer aborts it. Enable reads 0 and no further memory request is made even when its request line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_size | output | 2 | Unit width code |
| mem_sysbus | output | 1 | Bus select for this access |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Access failed (valid with ready) |
| dreq | input | 16 | Peripheral request lines (line 0 unused) |
| dgrant | output | 16 | Peripheral grant pulses |
| irq | output | 1 | Interrupt level |

## Verification
The transfer function is run with four stimulus sets, each of which rules out a different class of fault.
- Single word units with an incrementing source and a decrementing destination, and no memory wait states. This separates the step direction and the size of each step code.
- A burst of byte units with a decrementing source, a fixed destination and wait states. This shows the four-units-per-cycle rule and confirms that steps are applied per unit, not per cycle.
- A paced half-word transfer whose request line is dropped right after the first grant. This freezes the engine between cycles, so the remaining count and the ignored address write can be read exactly.
- An error injected on a write, a zero-count start and an abort. These show that the three terminations differ in status, count and bus activity.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} phase_e;

    localparam int B_EN      = 0;
    localparam int B_FIN     = 1;
    localparam int B_FIN_IE  = 2;
    localparam int B_BURST   = 3;
    localparam int B_ERR     = 4;
    localparam int B_ERR_IE  = 5;
    localparam int B_SRC_SYS = 6;
    localparam int B_DST_SYS = 7;
    localparam int F_SSTEP   = 8;
    localparam int F_DSTEP   = 12;
    localparam int F_DLINE   = 16;
    localparam int F_WIDTH   = 20;
    localparam int F_SLINE   = 24;

    // configuration bits held in the control word (status and enable kept apart)
    localparam logic [31:0] CFG_MASK = 32'h0F3F_77EC;
endpackage

// File: rtl/dma_step.sv
module dma_step #(
    parameter int AW = 32
) (
    input  logic [2:0]    code,
    output logic [AW-1:0] delta
);
    logic [AW-1:0] mag;

    always_comb begin
        case (code[1:0])
            2'd1:    mag = AW'(1);
            2'd2:    mag = AW'(2);
            2'd3:    mag = AW'(4);
            default: mag = '0;
        endcase
        delta = code[2] ? (~mag + AW'(1)) : mag;
    end
endmodule

// File: rtl/dma_pace.sv
module dma_pace #(
    parameter int LINE_W = 4,
    localparam int NLINE = 1 << LINE_W
) (
    input  logic [LINE_W-1:0] src_line,
    input  logic [LINE_W-1:0] dst_line,
    input  logic [NLINE-1:0]  preq,
    output logic              go,
    output logic [NLINE-1:0]  mask
);
    always_comb begin
        mask = '0;
        for (int i = 1; i < NLINE; i++) begin
            if (src_line == LINE_W'(i) || dst_line == LINE_W'(i)) mask[i] = 1'b1;
        end
        go = ((src_line == '0) || preq[src_line]) &&
             ((dst_line == '0) || preq[dst_line]);
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 24,
    parameter int LINE_W    = 4,
    parameter int BURST_LEN = 4,
    localparam int NLINE    = 1 << LINE_W,
    localparam int UW       = $clog2(BURST_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [1:0]        mem_size,
    output logic              mem_sysbus,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    input  logic [NLINE-1:0]  dreq,
    output logic [NLINE-1:0]  dgrant,
    output logic              irq
);
    typedef struct packed {
        phase_e          ph;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [CW-1:0]   cnt;
        logic [31:0]     cfg;
        logic            fin;
        logic            err;
        logic [UW-1:0]   unit;
        logic [DW-1:0]   hold;
        logic [NLINE-1:0] grant;
    } chan_t;

    chan_t q, n;
    logic [AW-1:0]    src_delta, dst_delta;
    logic             go;
    logic [NLINE-1:0] line_mask;
    logic             fin_set, err_set, fin_keep, err_keep, unit_last;

    dma_step #(.AW(AW)) u_src_step (.code(q.cfg[F_SSTEP +: 3]), .delta(src_delta));
    dma_step #(.AW(AW)) u_dst_step (.code(q.cfg[F_DSTEP +: 3]), .delta(dst_delta));

    dma_pace #(.LINE_W(LINE_W)) u_pace (
        .src_line (q.cfg[F_SLINE +: LINE_W]),
        .dst_line (q.cfg[F_DLINE +: LINE_W]),
        .preq     (dreq),
        .go       (go),
        .mask     (line_mask)
    );

    always_comb begin
        n         = q;
        n.grant   = '0;
        fin_set   = 1'b0;
        err_set   = 1'b0;
        unit_last = !q.cfg[B_BURST] || (q.unit == UW'(BURST_LEN - 1));

        case (q.ph)
            ST_WAIT: if (go) n.ph = ST_RD;
            ST_RD: if (mem_ready) begin
                if (mem_err) begin
                    err_set = 1'b1;
                    n.ph    = ST_IDLE;
                end else begin
                    n.hold = mem_rdata;
                    n.src  = q.src + src_delta;
                    n.ph   = ST_WR;
                end
            end
            ST_WR: if (mem_ready) begin
                if (mem_err) begin
                    err_set = 1'b1;
                    n.ph    = ST_IDLE;
                end else begin
                    n.dst = q.dst + dst_delta;
                    if (unit_last) begin
                        n.grant = line_mask;
                        n.cnt   = q.cnt - CW'(1);
                        n.unit  = '0;
                        if (q.cnt == CW'(1)) begin
                            fin_set = 1'b1;
                            n.ph    = ST_IDLE;
                        end else begin
                            n.ph = ST_WAIT;
                        end
                    end else begin
                        n.unit = q.unit + UW'(1);
                        n.ph   = ST_RD;
                    end
                end
            end
            default: ;
        endcase

        fin_keep = q.fin;
        err_keep = q.err;
        if (reg_we) begin
            case (reg_addr)
                2'd0: if (q.ph == ST_IDLE) n.src = reg_wdata[AW-1:0];
                2'd1: if (q.ph == ST_IDLE) n.dst = reg_wdata[AW-1:0];
                2'd2: if (q.ph == ST_IDLE) n.cnt = reg_wdata[CW-1:0];
                default: begin
                    n.cfg    = reg_wdata & CFG_MASK;
                    fin_keep = q.fin & reg_wdata[B_FIN];
                    err_keep = q.err & reg_wdata[B_ERR];
                    if (!reg_wdata[B_EN]) begin
                        n.ph = ST_IDLE;
                    end else if (q.ph == ST_IDLE) begin
                        n.unit = '0;
                        if (q.cnt == '0) fin_set = 1'b1;
                        else             n.ph    = ST_WAIT;
                    end
                end
            endcase
        end
        n.fin = fin_keep | fin_set;
        n.err = err_keep | err_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = 32'(q.src);
            2'd1:    reg_rdata = 32'(q.dst);
            2'd2:    reg_rdata = 32'(q.cnt);
            default: reg_rdata = q.cfg | (32'(q.err) << B_ERR) |
                                 (32'(q.fin) << B_FIN) | 32'(q.ph != ST_IDLE);
        endcase
    end

    assign mem_req    = (q.ph == ST_RD) || (q.ph == ST_WR);
    assign mem_we     = (q.ph == ST_WR);
    assign mem_addr   = mem_we ? q.dst : q.src;
    assign mem_wdata  = q.hold;
    assign mem_size   = q.cfg[F_WIDTH +: 2];
    assign mem_sysbus = mem_we ? q.cfg[B_DST_SYS] : q.cfg[B_SRC_SYS];
    assign dgrant     = q.grant;
    assign irq        = (q.fin & q.cfg[B_FIN_IE]) | (q.err & q.cfg[B_ERR_IE]);

    AST_CNT_DOWN_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.ph) != ST_IDLE && q.cnt != $past(q.cnt)) |-> q.cnt == $past(q.cnt) - CW'(1)); // R8
    AST_GRANT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|dgrant) |-> $past(mem_req && mem_we && mem_ready && !mem_err)); // R7
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == ST_WAIT && !go) |=> (q.ph != ST_RD)); // R7
    AST_FIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fin) |-> !mem_req); // R6
    AST_ERR_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> $past(mem_req && mem_ready && mem_err)); // R9
endmodule

// File: tb/tb_dma_chan.sv
module tb_dma_chan;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_sysbus;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        mem_err = 1'b0;
    logic [15:0] dreq = '0;
    logic [15:0] dgrant;
    logic        irq;

    dma_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_size(mem_size), .mem_sysbus(mem_sysbus), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .mem_err(mem_err), .dreq(dreq), .dgrant(dgrant),
        .irq(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        bit          sys;
    } xfer_t;

    xfer_t exp_q[$];
    int    total = 0, bad = 0;
    int    txn = 0, err_at = -1, lat = 0, wait_n = 0;
    int    quiet_viol = 0;
    bit    quiet = 0;
    bit    finished = 0;
    logic [1:0]  exp_size = '0;
    int    grant_cnt[16];
    logic [15:0] gprev = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] stp(input logic [2:0] c);
        case (c)
            3'd1: stp = 32'd1;
            3'd2: stp = 32'd2;
            3'd3: stp = 32'd4;
            3'd5: stp = -32'sd1;
            3'd6: stp = -32'sd2;
            3'd7: stp = -32'sd4;
            default: stp = 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] a);
        pat = a ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] mk(input bit en, input bit fie, input bit burst, input bit eie,
                                       input bit ssys, input bit dsys, input logic [2:0] ss,
                                       input logic [2:0] ds, input logic [3:0] dl,
                                       input logic [1:0] w, input logic [3:0] sl);
        mk = 32'(en) | (32'(fie) << 2) | (32'(burst) << 3) | (32'(eie) << 5) |
             (32'(ssys) << 6) | (32'(dsys) << 7) | (32'(ss) << 8) | (32'(ds) << 12) |
             (32'(dl) << 16) | (32'(w) << 20) | (32'(sl) << 24);
    endfunction

    task automatic enq(input logic [31:0] s, input logic [31:0] d, input logic [2:0] sc,
                       input logic [2:0] dc, input bit burst, input int cyc,
                       input bit ssys, input bit dsys);
        logic [31:0] a = s, b = d;
        for (int c = 0; c < cyc; c++) begin
            for (int u = 0; u < (burst ? 4 : 1); u++) begin
                exp_q.push_back('{we: 1'b0, addr: a, data: '0, sys: ssys});
                exp_q.push_back('{we: 1'b1, addr: b, data: pat(a), sys: dsys});
                a = a + stp(sc);
                b = b + stp(dc);
            end
        end
    endtask

    // Reference memory and bus monitor, evaluated every clock
    always @(negedge clk) begin
        xfer_t e;
        for (int i = 0; i < 16; i++) begin
            if (dgrant[i]) grant_cnt[i]++;
            if (dgrant[i] && gprev[i]) chk(0, "R7 grant longer than one clock", 2, 1);
        end
        gprev = dgrant;
        if (quiet && mem_req) quiet_viol++;
        if (mem_ready) begin
            mem_ready = 1'b0;
            mem_err   = 1'b0;
            wait_n    = 0;
        end else if (mem_req && rst_n) begin
            if (wait_n >= lat) begin
                txn++;
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected memory access", mem_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(mem_we == e.we && mem_addr == e.addr, "R3 R4 access address/direction",
                        {31'(0), mem_we, mem_addr}, {31'(0), e.we, e.addr});
                    if (e.we) chk(mem_wdata == e.data, "R4 write data", mem_wdata, e.data);
                    chk(mem_size == exp_size && mem_sysbus == e.sys, "R4 size/bus select",
                        {mem_size, mem_sysbus}, {exp_size, e.sys});
                end
                mem_ready = 1'b1;
                mem_rdata = pat(mem_addr);
                mem_err   = (txn == err_at);
            end else begin
                wait_n++;
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd3, v);
            if (!v[0]) break;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int t0;
        for (int i = 0; i < 16; i++) grant_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        chk(irq == 0 && mem_req == 0 && dgrant == 0, "R1 outputs idle", {irq, mem_req, dgrant}, 0);

        // R2 register map
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v);
        chk(v == 32'h00FF_FFFF, "R2 count width", v, 32'h00FF_FFFF);
        wr(2'd3, 32'hFFFF_FFFE); rd(2'd3, v);
        chk(v == 32'h0F3F_77EC, "R2 control fields", v, 32'h0F3F_77EC);
        wr(2'd0, 32'h1234_5678); rd(2'd0, v);
        chk(v == 32'h1234_5678, "R2 source register", v, 32'h1234_5678);
        wr(2'd3, 32'h0);

        // R3 R4 R6: single word units, source +4, destination -4
        lat = 0; exp_size = 2'd0;
        wr(2'd0, 32'h0000_0100); wr(2'd1, 32'h8000_0010); wr(2'd2, 32'd3);
        enq(32'h100, 32'h8000_0010, 3'd3, 3'd7, 0, 3, 1, 0);
        wr(2'd3, mk(1, 1, 0, 0, 1, 0, 3'd3, 3'd7, 4'd0, 2'd0, 4'd0));
        wait_idle();
        chk(exp_q.size() == 0, "R4 all units moved", exp_q.size(), 0);
        rd(2'd3, v);
        chk(v[1] == 1 && v[0] == 0, "R6 finish set and enable cleared", v[1:0], 2'b10);
        chk(irq == 1, "R6 irq from finish", irq, 1);
        rd(2'd0, v); chk(v == 32'h10C, "R3 source final", v, 32'h10C);
        rd(2'd1, v); chk(v == 32'h8000_0004, "R3 destination final", v, 32'h8000_0004);
        rd(2'd2, v); chk(v == 0, "R8 count at end", v, 0);
        wr(2'd3, 32'h0);
        chk(irq == 0, "R10 finish cleared by zero write", irq, 0);

        // R5: burst of bytes, source -1, destination fixed, wait states
        lat = 2; exp_size = 2'd2; t0 = txn;
        wr(2'd0, 32'h2000); wr(2'd1, 32'h3000); wr(2'd2, 32'd2);
        enq(32'h2000, 32'h3000, 3'd5, 3'd0, 1, 2, 0, 0);
        wr(2'd3, mk(1, 0, 1, 0, 0, 0, 3'd5, 3'd0, 4'd0, 2'd2, 4'd0));
        wait_idle();
        chk(txn - t0 == 16, "R5 four units per cycle", txn - t0, 16);
        chk(exp_q.size() == 0, "R5 sequence complete", exp_q.size(), 0);
        rd(2'd0, v); chk(v == 32'h1FF8, "R3 R5 source after burst", v, 32'h1FF8);
        rd(2'd1, v); chk(v == 32'h3000, "R3 fixed destination", v, 32'h3000);
        chk(irq == 0, "R6 no irq with finish enable off", irq, 0);
        wr(2'd3, 32'h0);

        // R7 R8 R12: paced by source line 3
        lat = 1; exp_size = 2'd1; dreq = '0; quiet = 1; quiet_viol = 0;
        for (int i = 0; i < 16; i++) grant_cnt[i] = 0;
        wr(2'd0, 32'h1000); wr(2'd1, 32'h4000); wr(2'd2, 32'd3);
        enq(32'h1000, 32'h4000, 3'd3, 3'd1, 0, 3, 0, 1);
        wr(2'd3, mk(1, 1, 0, 0, 0, 1, 3'd3, 3'd1, 4'd0, 2'd1, 4'd3));
        repeat (20) @(negedge clk);
        chk(quiet_viol == 0, "R7 no access without request", quiet_viol, 0);
        quiet = 0;
        dreq[3] = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            #1;
            if (dgrant[3]) begin dreq[3] = 1'b0; break; end
        end
        repeat (5) @(negedge clk);
        rd(2'd2, v); chk(v == 2, "R8 remaining cycles", v, 2);
        wr(2'd0, 32'hDEAD_0000); rd(2'd0, v);
        chk(v == 32'h1004, "R12 address write ignored while busy", v, 32'h1004);
        dreq[3] = 1'b1;
        wait_idle();
        dreq[3] = 1'b0;
        chk(grant_cnt[3] == 3, "R7 one grant per cycle", grant_cnt[3], 3);
        chk(grant_cnt[5] == 0 && grant_cnt[1] == 0, "R7 no grant on other lines", grant_cnt[5], 0);
        rd(2'd1, v); chk(v == 32'h4003, "R3 destination +1", v, 32'h4003);
        wr(2'd3, 32'h0);

        // R9 R10: error on first write
        lat = 0; exp_size = 2'd0; err_at = txn + 2;
        wr(2'd0, 32'h500); wr(2'd1, 32'h600); wr(2'd2, 32'd2);
        enq(32'h500, 32'h600, 3'd0, 3'd0, 0, 2, 0, 0);
        wr(2'd3, mk(1, 1, 0, 1, 0, 0, 3'd0, 3'd0, 4'd0, 2'd0, 4'd0));
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 2, "R9 transfer stopped after error", exp_q.size(), 2);
        exp_q.delete(); err_at = -1;
        rd(2'd3, v);
        chk(v[4] == 1 && v[1] == 0 && v[0] == 0, "R9 error status", v[4:0], 5'b10000);
        chk(irq == 1, "R9 irq from error", irq, 1);
        rd(2'd2, v); chk(v == 2, "R9 count not decremented", v, 2);
        wr(2'd3, 32'h30); rd(2'd3, v);
        chk(v[4] == 1, "R10 writing one keeps status", v[4], 1);
        wr(2'd3, 32'h20); rd(2'd3, v);
        chk(v[4] == 0 && irq == 0, "R10 writing zero clears status", {v[4], irq}, 0);

        // R11: zero count start
        quiet = 1; quiet_viol = 0;
        wr(2'd2, 32'd0);
        wr(2'd3, mk(1, 1, 0, 0, 0, 0, 3'd1, 3'd1, 4'd0, 2'd0, 4'd0));
        rd(2'd3, v);
        chk(v[1] == 1 && v[0] == 0, "R11 immediate finish", v[1:0], 2'b10);
        repeat (5) @(negedge clk);
        chk(quiet_viol == 0 && irq == 1, "R11 no bus traffic", {quiet_viol[0], irq}, 1);
        wr(2'd3, 32'h0);

        // R13: abort while waiting on destination line 5
        dreq = '0; quiet_viol = 0;
        wr(2'd0, 32'h700); wr(2'd2, 32'd4);
        wr(2'd3, mk(1, 0, 0, 0, 0, 0, 3'd1, 3'd1, 4'd5, 2'd0, 4'd0));
        repeat (5) @(negedge clk);
        wr(2'd3, mk(0, 0, 0, 0, 0, 0, 3'd1, 3'd1, 4'd5, 2'd0, 4'd0));
        rd(2'd3, v); chk(v[0] == 0, "R13 enable reads zero after abort", v[0], 0);
        dreq[5] = 1'b1;
        repeat (10) @(negedge clk);
        chk(quiet_viol == 0, "R13 no access after abort", quiet_viol, 0);
        rd(2'd2, v); chk(v == 4, "R13 count untouched", v, 4);
        dreq = '0; quiet = 0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule